// File: doc/BRIEF.md
# Colour-Matrix Coefficient Float Encoder

This block turns one colour-conversion matrix coefficient into the 16-bit floating code that a display pipe's colour-space-conversion unit holds in its coefficient storage. The coefficient arrives as a 64-bit two's-complement fixed-point number with 32 fractional bits, so unity is `0x1_0000_0000`. The block first limits the value to the range the code can represent. It then sorts the magnitude into one of six power-of-two bands. Each band supplies an exponent code and the position of a 9-bit mantissa window. The window is rounded, and the sign, exponent and mantissa are packed into the output word.

The exponent codes do not rise with magnitude. The four bands below one use codes 3, 2, 1 and 0 as the magnitude grows, and the two bands from one to four use codes 7 and 6. The mantissa window moves up one bit for each band, and the leading bit of each band lies above the window. A configuration path streams coefficients through a valid/ready input. Each accepted coefficient gives one code on a valid/ready output, registered one cycle later.

Top module: `csc_coef_encoder`

## Requirements
- R1: A coefficient above 3.9921875 (`0x3_FE00_0000`) is encoded exactly as 3.9921875 is, which gives code `0x6FF0`.
- R2: A coefficient below -4.0 is encoded exactly as -4.0 is, which gives code `0xE000`.
- R3: The exponent field is chosen from the clamped magnitude m. It is 3 for m < 0.125, 2 for 0.125 <= m < 0.25, 1 for 0.25 <= m < 0.5, 0 for 0.5 <= m < 1.0, 7 for 1.0 <= m < 2.0 and 6 for m >= 2.0. A band edge value belongs to the upper band.
- R4: The mantissa window is bits [L+8:L] of the 35-bit magnitude. L is 19, 20, 21, 22, 23 or 24 for the bands of R3, taken from the smallest band to the largest.
- R5: Rounding adds magnitude bit L-1 to the 9-bit window.
- R6: When the rounding carry leaves 9 bits, the mantissa saturates at `0x1FF`.
- R7: The output code holds the sign in bit 15, the exponent in bits 14:12 and the mantissa in bits 11:3, and bits 2:0 are always zero.
- R8: Bit 15 is set exactly when the clamped coefficient is negative. The mantissa field of a negative value equals the field of its magnitude.
- R9: A coefficient taken while `in_valid` and `in_ready` are both high shows on `out_code` with `out_valid` high after one clock edge. `in_ready` is high when the output stage is empty or is being drained. A result that is not yet taken stays unchanged.
- R10: After a synchronous active-low reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Coefficient offered |
| in_ready | output | 1 | Block can take a coefficient this cycle |
| in_coef | input | 64 | Signed fixed-point coefficient, 32 fractional bits |
| out_valid | output | 1 | Encoded code present |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | 16 | Packed sign, exponent and mantissa |

## Verification
The bench drives each band edge exactly: 0.125, 0.25, 0.5, 1.0 and 2.0. It also drives the value one LSB below the lowest edge. A band selector with an off-by-one comparison would return the wrong exponent code there, and a window misplaced by one bit would return a halved or doubled mantissa. Inputs just past each clamp limit are chosen so that an unclamped encoding differs from the clamped one, which exposes a missing or misplaced clamp. A window of all ones with the round bit set checks that the carry saturates and does not wrap to zero. Negative values check that the mantissa field carries the magnitude and not a two's-complement pattern. A stalled consumer checks that the held result does not change and that no second coefficient is taken.

// File: rtl/csc_enc_pkg.sv
// Package: shared constants and band helpers for the coefficient encoder.
// Assumes the magnitude bands are fixed powers of two around unity.
package csc_enc_pkg;

    localparam int EXP_W   = 3;
    localparam int NBANDS  = 6;
    localparam int BAND_W  = $clog2(NBANDS);

    // Exponent code of band b (0 = smallest magnitude band).
    function automatic logic [EXP_W-1:0] band_exp(input int b);
        int code;
        code = (b < 4) ? (3 - b) : (11 - b);
        return EXP_W'(code);
    endfunction

    // Mantissa LSB position of band b for a value with frac_w fraction bits.
    function automatic int band_lsb(input int frac_w, input int b);
        return frac_w - 13 + b;
    endfunction

endpackage

// File: rtl/csc_clamp_abs.sv
// Module: csc_clamp_abs
// Limits a signed fixed-point coefficient to [-4.0, 4.0 - 1/128] and
// splits it into a sign flag and an unsigned magnitude.
// Assumes FRAC_W >= 13 and COEF_W > FRAC_W + 3.
module csc_clamp_abs #(
    parameter int COEF_W = 64,
    parameter int FRAC_W = 32,
    parameter int MAG_W  = FRAC_W + 3
) (
    input  logic signed [COEF_W-1:0] coef,
    output logic                     neg,
    output logic [MAG_W-1:0]         mag
);
    localparam logic signed [COEF_W-1:0] FOUR =
        $signed(COEF_W'(1) << (FRAC_W + 2));
    localparam logic signed [COEF_W-1:0] STEP =
        $signed(COEF_W'(1) << (FRAC_W - 7));
    localparam logic signed [COEF_W-1:0] HI = FOUR - STEP;
    localparam logic signed [COEF_W-1:0] LO = -FOUR;

    logic signed [COEF_W-1:0] clamped;
    logic signed [COEF_W-1:0] absval;

    // Saturate the input into the legal range.
    always_comb begin
        if (coef > HI)
            clamped = HI;
        else if (coef < LO)
            clamped = LO;
        else
            clamped = coef;
    end

    // Take sign and magnitude of the clamped value.
    always_comb begin
        neg    = clamped[COEF_W-1];
        absval = neg ? -clamped : clamped;
        mag    = absval[MAG_W-1:0];
    end

endmodule

// File: rtl/csc_band_sel.sv
// Module: csc_band_sel
// Sorts a magnitude into one of NBANDS power-of-two bands. Band 0 is below
// 0.125. Each higher band starts at twice the previous edge. An exact
// edge value falls in the upper band.
module csc_band_sel
    import csc_enc_pkg::*;
#(
    parameter int FRAC_W = 32,
    parameter int MAG_W  = FRAC_W + 3
) (
    input  logic [MAG_W-1:0]  mag,
    output logic [BAND_W-1:0] band
);
    logic [NBANDS-1:1] at_or_above;

    // One comparator per band edge.
    for (genvar e = 1; e < NBANDS; e++) begin : g_edge
        localparam logic [MAG_W-1:0] EDGE = MAG_W'(1) << (FRAC_W - 4 + e);
        assign at_or_above[e] = (mag >= EDGE);
    end

    // Band index is the number of edges passed (a thermometer count).
    always_comb begin
        band = '0;
        for (int e = 1; e < NBANDS; e++)
            band = band + BAND_W'(at_or_above[e]);
    end

endmodule

// File: rtl/csc_mant_round.sv
// Module: csc_mant_round
// Picks the band's 9-bit mantissa window out of the magnitude, adds the
// bit below the window as rounding and saturates on overflow.
// Assumes band < NBANDS.
module csc_mant_round
    import csc_enc_pkg::*;
#(
    parameter int FRAC_W = 32,
    parameter int MAG_W  = FRAC_W + 3,
    parameter int MANT_W = 9
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic [BAND_W-1:0] band,
    output logic [MANT_W-1:0] mant
);
    logic [MANT_W-1:0] window [NBANDS];
    logic              half   [NBANDS];
    logic [MANT_W-1:0] win_sel;
    logic              half_sel;
    logic [MANT_W:0]   sum;

    // Window and round bit per band.
    for (genvar b = 0; b < NBANDS; b++) begin : g_band
        localparam int LSB = band_lsb(FRAC_W, b);
        assign window[b] = mag[LSB +: MANT_W];
        assign half[b]   = mag[LSB-1];
    end

    // Select the active band's window.
    always_comb begin
        win_sel  = '0;
        half_sel = 1'b0;
        for (int b = 0; b < NBANDS; b++) begin
            if (band == BAND_W'(b)) begin
                win_sel  = window[b];
                half_sel = half[b];
            end
        end
    end

    // Round half up and clip the carry.
    always_comb begin
        sum  = {1'b0, win_sel} + (MANT_W+1)'(half_sel);
        mant = sum[MANT_W] ? {MANT_W{1'b1}} : sum[MANT_W-1:0];
    end

endmodule

// File: rtl/csc_coef_encoder.sv
// Module: csc_coef_encoder (top)
// Encodes one fixed-point matrix coefficient per handshake into a 16-bit
// sign / exponent / mantissa code, with one registered output stage.
// Assumes a synchronous active-low reset, and an output word that is exactly
// 1 + EXP_W + MANT_W + 3 bits wide.
module csc_coef_encoder
    import csc_enc_pkg::*;
#(
    parameter int COEF_W = 64,
    parameter int FRAC_W = 32,
    parameter int MANT_W = 9,
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_coef,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code
);
    localparam int MAG_W  = FRAC_W + 3;
    localparam int PAD_W  = CODE_W - 1 - EXP_W - MANT_W;

    logic              neg;
    logic [MAG_W-1:0]  mag;
    logic [BAND_W-1:0] band;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  exp_code;
    logic [CODE_W-1:0] code_next;
    logic              take;

    csc_clamp_abs #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_clamp (
        .coef (in_coef),
        .neg  (neg),
        .mag  (mag)
    );

    csc_band_sel #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_band (
        .mag  (mag),
        .band (band)
    );

    csc_mant_round #(.FRAC_W(FRAC_W), .MAG_W(MAG_W), .MANT_W(MANT_W)) u_mant (
        .mag  (mag),
        .band (band),
        .mant (mant)
    );

    // Map band index to its exponent code.
    always_comb begin
        exp_code = '0;
        for (int b = 0; b < NBANDS; b++)
            if (band == BAND_W'(b))
                exp_code = band_exp(b);
    end

    // Pack fields into the output word.
    always_comb begin
        code_next = {neg, exp_code, mant, {PAD_W{1'b0}}};
    end

    // Handshake: accept when the output stage is empty or draining.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_code  <= code_next;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/csc_coef_encoder_chk.sv
// Module: csc_coef_encoder_chk
// Property checker for the encoder's port behaviour, bound to every instance.
module csc_coef_encoder_chk #(
    parameter int COEF_W = 64,
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [COEF_W-1:0] in_coef,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CODE_W-1:0] out_code
);
    // R7: padding bits stay zero.
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_code[2:0] == 3'b000);

    // R3: exponent codes 4 and 5 are never produced.
    a_r3_exp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code[14:12] != 3'd4 && out_code[14:12] != 3'd5));

    // R9: an accepted coefficient yields a valid result one edge later.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R9: a stalled result holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_code));

    // R8: sign bit follows the sign of the accepted coefficient.
    a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_code[15] == $past(in_coef[COEF_W-1]));

endmodule

bind csc_coef_encoder csc_coef_encoder_chk #(.COEF_W(COEF_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_csc_coef_encoder.sv
module tb_csc_coef_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_coef = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csc_coef_encoder dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
    );

    localparam logic signed [63:0] MAXV = 64'sh3_FE00_0000;
    localparam logic signed [63:0] MINV = -64'sh4_0000_0000;

    // Reference model written from the requirements.
    function automatic logic [15:0] ref_code(input logic signed [63:0] v);
        logic signed [63:0] c;
        logic [63:0] a;
        int lsb;
        logic [2:0] e;
        logic [9:0] m;
        c = (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
        a = (c < 0) ? 64'(-c) : 64'(c);
        if (a < 64'h2000_0000)        begin e = 3'd3; lsb = 19; end
        else if (a < 64'h4000_0000)   begin e = 3'd2; lsb = 20; end
        else if (a < 64'h8000_0000)   begin e = 3'd1; lsb = 21; end
        else if (a < 64'h1_0000_0000) begin e = 3'd0; lsb = 22; end
        else if (a < 64'h2_0000_0000) begin e = 3'd7; lsb = 23; end
        else                          begin e = 3'd6; lsb = 24; end
        m = {1'b0, a[lsb +: 9]} + 10'(a[lsb-1]);
        if (m > 10'd511) m = 10'd511;
        return {c < 0, e, m[8:0], 3'b000};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Push one coefficient with the consumer ready and compare.
    task automatic send_exp(input logic signed [63:0] v, input logic [15:0] exp,
                            input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_coef   = v;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_code == exp && ref_code(v) == exp, req, out_code, exp);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R10 out_valid", 16'(out_valid), 16'h0);
        check(in_ready == 1'b1, "R10 in_ready", 16'(in_ready), 16'h1);
    endtask

    task automatic t_band_edges;
        send_exp(64'sh0,           16'h3000, "R3 zero");
        send_exp(64'sh2000_0000,   16'h2000, "R3 edge 0.125");
        send_exp(64'sh4000_0000,   16'h1000, "R3 edge 0.25");
        send_exp(64'sh8000_0000,   16'h0000, "R3 edge 0.5");
        send_exp(64'sh1_0000_0000, 16'h7000, "R3 edge 1.0");
        send_exp(64'sh2_0000_0000, 16'h6000, "R3 edge 2.0");
        send_exp(64'sh1FFF_FFFF,   16'h3FF8, "R6 just below 0.125");
    endtask

    task automatic t_windows;
        send_exp(64'sh0008_0000,   16'h3008, "R4 band0 lsb 19");
        send_exp(64'sh3000_0000,   16'h2800, "R4 band1 0.1875");
        send_exp(64'sh1_8000_0000, 16'h7800, "R4 band4 1.5");
        send_exp(64'sh8020_0000,   16'h0008, "R5 round up 0.5 band");
        send_exp(64'sh8010_0000,   16'h0000, "R5 below half no round");
    endtask

    task automatic t_clamps;
        send_exp(MAXV,                    16'h6FF0, "R1 max exact");
        send_exp(64'sh3_FF80_0000,        16'h6FF0, "R1 just above max");
        send_exp(64'sh7FFF_FFFF_FFFF_FFFF, 16'h6FF0, "R1 most positive");
        send_exp(MINV,                    16'hE000, "R2 min exact");
        send_exp(-64'sh5_0000_0000,       16'hE000, "R2 -5.0");
        send_exp(64'sh8000_0000_0000_0000, 16'hE000, "R2 most negative");
    endtask

    task automatic t_saturate_and_sign;
        send_exp(64'shFFE0_0000,   16'h0FF8, "R6 carry saturates");
        send_exp(-64'shFFE0_0000,  16'h8FF8, "R8 negative saturated");
        send_exp(-64'sh1_8000_0000, 16'hF800, "R8 -1.5 magnitude field");
        send_exp(-64'sh3000_0000,  16'hA800, "R8 -0.1875 magnitude field");
        send_exp(-64'sh0008_0000,  16'hB008, "R7 R8 small negative layout");
    endtask

    task automatic t_sweep;
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 300; i++) begin
            logic signed [63:0] v;
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            v = $signed(s) >>> (28 + int'(s[3:0]));
            @(negedge clk);
            in_valid  = 1'b1;
            in_coef   = v;
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid && out_code == ref_code(v), "R3 R4 R5 sweep",
                  out_code, ref_code(v));
        end
    endtask

    task automatic t_stall;
        logic [15:0] first;
        first = ref_code(64'sh1_8000_0000);
        @(negedge clk);
        in_valid  = 1'b1;
        in_coef   = 64'sh1_8000_0000;
        out_ready = 1'b0;
        @(negedge clk);
        in_coef = 64'sh3000_0000;
        check(out_valid && out_code == first, "R9 first result", out_code, first);
        check(in_ready == 1'b0, "R9 ready low when full", 16'(in_ready), 16'h0);
        @(negedge clk);
        check(out_valid && out_code == first, "R9 held while stalled", out_code, first);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_code == 16'h2800, "R9 second after release",
              out_code, 16'h2800);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drained", 16'(out_valid), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_band_edges;
        t_windows;
        t_clamps;
        t_saturate_and_sign;
        t_stall;
        t_sweep;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule